// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This block sits between an address source and memory and sorts every request by the top nibble of its 32-bit virtual address. The nibble picks one of sixteen segments. Each segment is set on its own to one of two modes. In linear mode the block forms the physical address at once, by putting a programmed 4-bit base in place of the top nibble. In paged mode the block hands the virtual address to a separate page translation path and gives no physical address itself.

A user-mode access to a segment at or above a user limit is refused with a fault. The limit is a parameter and defaults to segment 0xB, so user code may reach 0x00000000 to 0xAFFFFFFF. While translation is switched off, every address passes through unchanged and no range check is made. The paged path can report its own faults back through this block. The block folds those faults into the same one-cycle fault pulse, which carries a 2-bit cause.

Segment modes, bases and the enable flag sit in registers on a simple write port. A write made on the same clock edge as a request takes effect only from the next request.

Top module: `vseg_translator`

## Requirements
- R1: After reset, translation is disabled, every segment is in paged mode, every base is 0 and all outputs are low.
- R2: While translation is disabled, a request returns rsp_valid one cycle later with rsp_paddr equal to the virtual address, whatever the mode flag and address are, and raises no fault.
- R3: Virtual address bits 31:28 select the segment. Bit i of the mode register (config address 0, wdata bits 15:0) set to 1 makes segment i linear, and set to 0 makes it paged.
- R4: For an enabled, linear segment, rsp_paddr is the segment's base nibble followed by virtual bits 27:0. Config address 2 holds the bases of segments 0 to 7, and address 3 holds those of segments 8 to 15. The base of segment k sits at bits 4*(k mod 8)+3 : 4*(k mod 8).
- R5: For an enabled, paged segment, page_req pulses one cycle later with page_vaddr equal to the virtual address, and rsp_valid stays low.
- R6: With translation enabled, a user-mode request whose segment is 0xB or above gives fault_valid with cause bit 0 set (2'b01). It gives neither rsp_valid nor page_req. A kernel request to the same address is translated normally, and a user request to segment 0xA is allowed.
- R7: A page_fault input pulse gives fault_valid one cycle later with cause bit 1 set (2'b10). If it coincides with a user range fault, the cause is 2'b11. fault_valid lasts one cycle for each event.
- R8: A configuration write on the same clock edge as a request does not affect that request. The request is translated with the settings held before the write.
- R9: Config address 1, wdata bit 0, is the translation enable.
- R10: Every result appears exactly one cycle after its request. Each request produces at most one of rsp_valid, page_req and a range fault, and no result appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | A translation request is present |
| req_vaddr | input | 32 | Virtual address |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| page_fault | input | 1 | Fault pulse reported by the paged path |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| rsp_valid | output | 1 | Physical address is valid |
| rsp_paddr | output | 32 | Physical address |
| page_req | output | 1 | Request to the page translation path |
| page_vaddr | output | 32 | Virtual address sent to the paged path |
| fault_valid | output | 1 | One-cycle fault pulse |
| fault_cause | output | 2 | Bit 0 = user range fault, bit 1 = paged-path fault |

## Verification
The bench probes the user-limit boundary at 0xAFFFFFFC against 0xB0000000, and repeats the high address in kernel mode. A design with an off-by-one limit would either fault on segment A or let segment B through. It lands a mode write and a disable write on the same edge as a request. A design that used the new settings at once would return a paged or passed-through result where the old linear result is due. It also raises a page fault together with a range fault, which shows whether the cause bits merge or one cause overwrites the other.

// File: rtl/vseg_pkg.sv
package vseg_pkg;

   // Outcome of classifying one request
   typedef enum logic [1:0] {
      CLS_NONE   = 2'd0,
      CLS_LINEAR = 2'd1,
      CLS_PAGED  = 2'd2,
      CLS_UFAULT = 2'd3
   } vseg_cls_e;

   localparam logic [1:0] CAUSE_USER = 2'b01;
   localparam logic [1:0] CAUSE_PAGE = 2'b10;

   localparam int REG_MODE   = 0;
   localparam int REG_ENABLE = 1;
   localparam int REG_BASE0  = 2;

endpackage

// File: rtl/vseg_cfg_regs.sv
module vseg_cfg_regs #(
   parameter int NSEG  = 16,
   parameter int SEG_W = 4,
   parameter int DW    = 32,
   parameter int AW    = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [AW-1:0]          addr,
   input  logic [DW-1:0]          wdata,
   output logic [NSEG-1:0]        mode,
   output logic [NSEG*SEG_W-1:0]  bases,
   output logic                   en
);
   import vseg_pkg::*;

   localparam int BPW = DW / SEG_W;
   localparam int NBW = NSEG / BPW;

   if (NSEG > DW) begin : g_bad_mode
      $error("mode register wider than write data");
   end
   if ((NSEG % BPW) != 0) begin : g_bad_base
      $error("segment count must fill whole base words");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= '0;
         en   <= 1'b0;
      end else if (we) begin
         if (int'(addr) == REG_MODE)   mode <= wdata[NSEG-1:0];
         if (int'(addr) == REG_ENABLE) en   <= wdata[0];
      end
   end

   for (genvar w = 0; w < NBW; w++) begin : g_base_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bases[w*DW +: DW] <= '0;
         else if (we && int'(addr) == REG_BASE0 + w)
            bases[w*DW +: DW] <= wdata;
      end
   end

   if (NSEG < DW) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^wdata[DW-1:NSEG];
   end

endmodule

// File: rtl/vseg_classify.sv
module vseg_classify #(
   parameter int ADDR_W     = 32,
   parameter int SEG_W      = 4,
   parameter int NSEG       = 16,
   parameter int USER_LIMIT = 11
) (
   input  logic [ADDR_W-1:0]        vaddr,
   input  logic                     user,
   input  logic                     en,
   input  logic [NSEG-1:0]          mode,
   input  logic [NSEG*SEG_W-1:0]    bases,
   output vseg_pkg::vseg_cls_e      cls,
   output logic [ADDR_W-1:0]        paddr
);
   import vseg_pkg::*;

   localparam int OFF_W = ADDR_W - SEG_W;

   if (OFF_W < 1) begin : g_bad_w
      $error("address must be wider than the segment field");
   end
   if (USER_LIMIT > NSEG || USER_LIMIT < 0) begin : g_bad_lim
      $error("user limit out of segment range");
   end

   logic [SEG_W-1:0] seg;
   logic [SEG_W-1:0] base;
   logic             over_limit;

   assign seg        = vaddr[ADDR_W-1 -: SEG_W];
   assign base       = bases[seg*SEG_W +: SEG_W];
   assign over_limit = (int'(seg) >= USER_LIMIT);

   always_comb begin
      cls   = CLS_PAGED;
      paddr = vaddr;
      if (!en) begin
         cls = CLS_LINEAR;
      end else if (user && over_limit) begin
         cls = CLS_UFAULT;
      end else if (mode[seg]) begin
         cls   = CLS_LINEAR;
         paddr = {base, vaddr[OFF_W-1:0]};
      end
   end

endmodule

// File: rtl/vseg_out_stage.sv
module vseg_out_stage #(
   parameter int ADDR_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  vseg_pkg::vseg_cls_e cls,
   input  logic [ADDR_W-1:0]   paddr,
   input  logic [ADDR_W-1:0]   vaddr,
   input  logic                page_fault,
   output logic                rsp_valid,
   output logic [ADDR_W-1:0]   rsp_paddr,
   output logic                page_req,
   output logic [ADDR_W-1:0]   page_vaddr,
   output logic                fault_valid,
   output logic [1:0]          fault_cause
);
   import vseg_pkg::*;

   logic [1:0] cause_d;

   always_comb begin
      cause_d = '0;
      if (req_valid && cls == CLS_UFAULT) cause_d = cause_d | CAUSE_USER;
      if (page_fault)                     cause_d = cause_d | CAUSE_PAGE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_paddr   <= '0;
         page_req    <= 1'b0;
         page_vaddr  <= '0;
         fault_valid <= 1'b0;
         fault_cause <= '0;
      end else begin
         rsp_valid   <= req_valid && cls == CLS_LINEAR;
         page_req    <= req_valid && cls == CLS_PAGED;
         fault_valid <= |cause_d;
         fault_cause <= cause_d;
         if (req_valid && cls == CLS_LINEAR) rsp_paddr  <= paddr;
         if (req_valid && cls == CLS_PAGED)  page_vaddr <= vaddr;
      end
   end

endmodule

// File: rtl/vseg_translator.sv
module vseg_translator #(
   parameter int ADDR_W     = 32,
   parameter int SEG_W      = 4,
   parameter int DW         = 32,
   parameter int USER_LIMIT = 11,
   localparam int NSEG      = 1 << SEG_W,
   localparam int NBW       = (NSEG * SEG_W) / DW,
   localparam int CFG_AW    = $clog2(2 + NBW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_vaddr,
   input  logic              req_user,
   input  logic              page_fault,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [DW-1:0]     cfg_wdata,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_paddr,
   output logic              page_req,
   output logic [ADDR_W-1:0] page_vaddr,
   output logic              fault_valid,
   output logic [1:0]        fault_cause
);
   import vseg_pkg::*;

   logic [NSEG-1:0]       cfg_mode;
   logic [NSEG*SEG_W-1:0] cfg_bases;
   logic                  cfg_en;
   vseg_cls_e             cls;
   logic [ADDR_W-1:0]     xl_paddr;

   vseg_cfg_regs #(
      .NSEG(NSEG), .SEG_W(SEG_W), .DW(DW), .AW(CFG_AW)
   ) i_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .mode(cfg_mode), .bases(cfg_bases), .en(cfg_en)
   );

   vseg_classify #(
      .ADDR_W(ADDR_W), .SEG_W(SEG_W), .NSEG(NSEG), .USER_LIMIT(USER_LIMIT)
   ) i_cls (
      .vaddr(req_vaddr), .user(req_user), .en(cfg_en), .mode(cfg_mode),
      .bases(cfg_bases), .cls(cls), .paddr(xl_paddr)
   );

   vseg_out_stage #(
      .ADDR_W(ADDR_W)
   ) i_out (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cls(cls),
      .paddr(xl_paddr), .vaddr(req_vaddr), .page_fault(page_fault),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .page_req(page_req),
      .page_vaddr(page_vaddr), .fault_valid(fault_valid),
      .fault_cause(fault_cause)
   );

endmodule

// File: rtl/vseg_translator_chk.sv
module vseg_translator_chk #(
   parameter int ADDR_W     = 32,
   parameter int SEG_W      = 4,
   parameter int USER_LIMIT = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_vaddr,
   input logic              req_user,
   input logic              page_fault,
   input logic              en,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] rsp_paddr,
   input logic              page_req,
   input logic [ADDR_W-1:0] page_vaddr,
   input logic              fault_valid,
   input logic [1:0]        fault_cause
);
   logic user_over;
   assign user_over = req_valid && req_user && en &&
                      (int'(req_vaddr[ADDR_W-1 -: SEG_W]) >= USER_LIMIT);

   // R10
   one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({rsp_valid, page_req, fault_valid && fault_cause[0]}) <= 1);

   // R10
   result_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid || page_req) |-> $past(req_valid));

   // R2
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !en) |=> (rsp_valid && rsp_paddr == $past(req_vaddr) && !fault_valid));

   // R4
   offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_paddr[ADDR_W-SEG_W-1:0] == $past(req_vaddr[ADDR_W-SEG_W-1:0]));

   // R5
   page_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      page_req |-> page_vaddr == $past(req_vaddr));

   // R6
   user_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      user_over |=> (fault_valid && fault_cause[0] && !rsp_valid && !page_req));

   // R7
   page_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      page_fault |=> (fault_valid && fault_cause[1]));

   // R7
   cause_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> fault_cause != 2'b00);

endmodule

bind vseg_translator vseg_translator_chk #(
   .ADDR_W(ADDR_W), .SEG_W(SEG_W), .USER_LIMIT(USER_LIMIT)
) i_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
   .req_user(req_user), .page_fault(page_fault), .en(cfg_en),
   .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .page_req(page_req),
   .page_vaddr(page_vaddr), .fault_valid(fault_valid),
   .fault_cause(fault_cause)
);

// File: tb/test_vseg_translator.sv
module test_vseg_translator;

   typedef struct packed {
      logic        rv;
      logic [31:0] pa;
      logic        pr;
      logic [31:0] pv;
      logic        fv;
      logic [1:0]  fc;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        req_user = 1'b0;
   logic        page_fault = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        rsp_valid, page_req, fault_valid;
   logic [31:0] rsp_paddr, page_vaddr;
   logic [1:0]  fault_cause;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   exp_t  exp_q[$];
   string tag_q[$];

   logic [15:0] m_mode = '0;
   logic [63:0] m_bases = '0;
   logic        m_en = 1'b0;

   always #5 clk = ~clk;

   vseg_translator i_vseg_translator (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_user(req_user), .page_fault(page_fault), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rsp_valid(rsp_valid),
      .rsp_paddr(rsp_paddr), .page_req(page_req), .page_vaddr(page_vaddr),
      .fault_valid(fault_valid), .fault_cause(fault_cause)
   );

   function automatic exp_t model(input logic rq, input logic [31:0] va,
                                  input logic us, input logic pf);
      exp_t e;
      logic [3:0] s;
      e = '0;
      s = va[31:28];
      if (rq) begin
         if (!m_en) begin
            e.rv = 1'b1; e.pa = va;
         end else if (us && s >= 4'hB) begin
            e.fv = 1'b1; e.fc[0] = 1'b1;
         end else if (m_mode[s]) begin
            e.rv = 1'b1; e.pa = {m_bases[s*4 +: 4], va[27:0]};
         end else begin
            e.pr = 1'b1; e.pv = va;
         end
      end
      if (pf) begin
         e.fv = 1'b1; e.fc[1] = 1'b1;
      end
      return e;
   endfunction

   task automatic step(input logic rq, input logic [31:0] va, input logic us,
                       input logic pf, input logic we, input logic [1:0] wa,
                       input logic [31:0] wd, input string tag);
      @(negedge clk);
      req_valid = rq; req_vaddr = va; req_user = us; page_fault = pf;
      cfg_we = we; cfg_addr = wa; cfg_wdata = wd;
      exp_q.push_back(model(rq, va, us, pf));
      tag_q.push_back(tag);
      if (we) begin
         case (wa)
            2'd0: m_mode = wd[15:0];
            2'd1: m_en   = wd[0];
            2'd2: m_bases[31:0]  = wd;
            2'd3: m_bases[63:32] = wd;
            default: ;
         endcase
      end
   endtask

   task automatic req(input logic [31:0] va, input logic us, input string tag);
      step(1'b1, va, us, 1'b0, 1'b0, 2'd0, 32'd0, tag);
   endtask

   task automatic wr(input logic [1:0] wa, input logic [31:0] wd, input string tag);
      step(1'b0, 32'd0, 1'b0, 1'b0, 1'b1, wa, wd, tag);
   endtask

   task automatic idle(input string tag);
      step(1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 2'd0, 32'd0, tag);
   endtask

   // Scoreboard monitor: one result per driven cycle, sampled after the edge
   always @(posedge clk) begin
      #2;
      if (rst_n && exp_q.size() > 0) begin
         exp_t  e;
         string t;
         logic  ok;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         ok = (rsp_valid == e.rv) && (page_req == e.pr) && (fault_valid == e.fv) &&
              (!e.rv || rsp_paddr == e.pa) && (!e.pr || page_vaddr == e.pv) &&
              (!e.fv || fault_cause == e.fc);
         checks++;
         if (!ok) begin
            fails++;
            $display("FAIL %s: got rv=%0b pa=%h pr=%0b pv=%h fv=%0b fc=%b, expected rv=%0b pa=%h pr=%0b pv=%h fv=%0b fc=%b",
                     t, rsp_valid, rsp_paddr, page_req, page_vaddr, fault_valid, fault_cause,
                     e.rv, e.pa, e.pr, e.pv, e.fv, e.fc);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000) begin
         fails++;
         $display("FAIL watchdog: got %0d cycles, expected at most 5000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs idle during reset
      checks++;
      if ({rsp_valid, page_req, fault_valid} != 3'b000) begin
         fails++;
         $display("FAIL R1 reset: got %b, expected 000", {rsp_valid, page_req, fault_valid});
      end
      rst_n = 1'b1;

      // R1/R2: disabled after reset, pass-through with no range check
      req(32'hC0001234, 1'b1, "R2 bypass user high");
      req(32'h00002000, 1'b0, "R2 bypass low");
      idle("R10 idle no output");

      // R9: enable; R1: all segments paged after reset
      wr(2'd1, 32'h1, "R9 enable write");
      req(32'hD004000C, 1'b0, "R1 reset mode paged");
      req(32'hC0001234, 1'b0, "R1 reset mode paged C");

      // R4: bases; R3: modes (B,C,E,F,4 linear)
      wr(2'd2, 32'h0004_0000, "R4 base low word");
      wr(2'd3, 32'h0804_B000, "R4 base high word");
      wr(2'd0, 32'h0000_D810, "R3 mode write");
      req(32'hC0001234, 1'b0, "R4 seg C to 4");
      req(32'hB0000010, 1'b0, "R4 seg B identity");
      req(32'hE1234567, 1'b0, "R4 seg E to 8");
      req(32'hF00000F0, 1'b0, "R4 seg F to 0");
      req(32'h4000ABCD, 1'b0, "R4 seg 4 identity");
      req(32'hD004000C, 1'b0, "R5 seg D paged");
      req(32'h00000000, 1'b0, "R5 seg 0 paged");
      req(32'hFFFFFFFF, 1'b0, "R3 top segment");

      // R6: user limit
      req(32'hB0000000, 1'b1, "R6 user seg B fault");
      req(32'hAFFFFFFC, 1'b1, "R6 user seg A allowed");
      req(32'hC0001234, 1'b1, "R6 user seg C fault");
      req(32'h4000ABCD, 1'b1, "R6 user seg 4 linear");

      // R7: paged-path faults
      step(1'b0, 32'd0, 1'b0, 1'b1, 1'b0, 2'd0, 32'd0, "R7 page fault alone");
      step(1'b1, 32'hF0000000, 1'b1, 1'b1, 1'b0, 2'd0, 32'd0, "R7 both causes");
      step(1'b1, 32'hD0000000, 1'b0, 1'b1, 1'b0, 2'd0, 32'd0, "R7 page fault with page req");
      idle("R7 pulse ends");

      // R8: write on the same edge as a request uses old settings
      step(1'b1, 32'hC0001234, 1'b0, 1'b0, 1'b1, 2'd0, 32'h0, "R8 mode write in flight");
      req(32'hC0001234, 1'b0, "R8 new mode applies");
      step(1'b1, 32'hB0000000, 1'b1, 1'b0, 1'b1, 2'd1, 32'h0, "R8 disable in flight");
      req(32'hB0000000, 1'b1, "R2 disabled user high passes");
      idle("R10 final idle");
      idle("R10 drain");

      @(negedge clk);
      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule